// File: doc/BRIEF.md
# Analog Supply Sequencer with Comparator Settling Gate

This controller decides when the on-chip voltage reference, its regulator and its charge pump run, and when the outputs of the analog comparators may be trusted. The reference runs whenever some analog function asks for it or a force setting holds it on. A 2-bit supply mode and a flag that says the supply is above 2.7 V together choose which rails run. When force is off, the comparator-valid gate opens only after a settling delay of either 100 or 550 ticks of a 1-microsecond timebase.

The controller is one state machine with four states. `ST_OFF` means the reference is off. `ST_SETTLE` means the reference is on and the delay is counting. `ST_READY` means the reference is on and the gate is open. `ST_FORCED` means the reference is held on by force and the gate is open. The transitions are:

- power-down: any state goes to `ST_OFF` when neither the request nor force is present.
- force-take: any state goes to `ST_FORCED` while force is set.
- start: `ST_OFF` goes to `ST_SETTLE` on a request without force.
- expire: `ST_SETTLE` goes to `ST_READY` on the tick that completes the delay.
- release: `ST_FORCED` goes to `ST_READY` when force drops and the request remains.

The delay length is fixed at the start transition. A timer clears whenever the machine leaves `ST_SETTLE`. The reference-ready and oscillator-enable outputs follow the reference enable with no delay.

Top module: `anasup_ctrl`

## Requirements
- R1: `ref_en` goes high on the clock edge after `analog_req|force_on` is first sampled high. It goes low on the edge after both are sampled low.
- R2: With `supply_mode`=00 (direct supply), `reg_en` and `pump_en` are 0 and `bypass_en` equals `ref_en`.
- R3: With `supply_mode`=01 (automatic) and no force, `reg_en` equals `ref_en` and `pump_en` equals `ref_en & ~vdd_high`, following `vdd_high` combinationally.
- R4: With `supply_mode`=10, `pump_en` equals `ref_en`. With 11, `pump_en` is 0. In both modes `reg_en` equals `ref_en` and `bypass_en` is 0.
- R5: A tick is counted when it is sampled at an edge where `ref_en`=1 and `cmp_valid`=0. `cmp_valid` rises on the edge that samples the N-th counted tick. N is 550 for modes 00 and 10 and for mode 01 with `vdd_high`=0. N is 100 for mode 11 and for mode 01 with `vdd_high`=1.
- R6: Force sets `cmp_valid` on the same edge as `ref_en`, with no delay. While force is active in mode 01, `pump_en`=`ref_en` whatever `vdd_high` is.
- R7: `ref_ready` and `osc_en` always equal `ref_en` and are never held by the settling delay.
- R8: `cmp_valid` falls on the same edge as `ref_en` falls. The next enable counts a full delay from zero.
- R9: The delay length is taken from `supply_mode`/`vdd_high` as sampled on the edge where `ref_en` rises. Later changes do not alter the count in progress.
- R10: When force drops while `analog_req` stays high, `ref_en` and `cmp_valid` stay 1 with no new delay.
- R11: While reset is asserted, and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| analog_req | input | 1 | Some analog function needs the reference |
| force_on | input | 1 | Hold reference on and bypass settling |
| supply_mode | input | 2 | 00 direct, 01 automatic, 10 pump always on, 11 pump always off |
| vdd_high | input | 1 | Supply is above 2.7 V |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| ref_en | output | 1 | Voltage reference enable |
| reg_en | output | 1 | Regulator enable |
| pump_en | output | 1 | Charge pump enable |
| bypass_en | output | 1 | Supply routed straight to the analog blocks |
| cmp_valid | output | 1 | Comparator outputs may be used |
| ref_ready | output | 1 | Reference-ready flag, not delayed |
| osc_en | output | 1 | Oscillator enable, not delayed |

## Verification
The bench targets these corner cases:

- Exact delay length in each mode. A timer off by one would open the gate one tick early or late.
- A change of `vdd_high` during the count. A design that did not latch the length would switch between 100 and 550 partway through.
- A request that drops mid-count and then returns. Keeping the partial count would open the gate too soon.
- Force that arrives during settling and is released with the request still present. A design that restarted the timer would close the gate, and one that ignored force would leave `cmp_valid` low.
- Automatic mode under force. A pump that still followed `vdd_high` would be wrong.

// File: rtl/anasup_pkg.sv
package anasup_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_AUTO     = 2'b01,
        MODE_PUMP_ON  = 2'b10,
        MODE_PUMP_OFF = 2'b11
    } sup_mode_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_SETTLE = 2'b01,
        ST_READY  = 2'b10,
        ST_FORCED = 2'b11
    } seq_state_e;

endpackage

// File: rtl/anasup_delay_sel.sv
module anasup_delay_sel
    import anasup_pkg::*;
(
    input  sup_mode_e mode,
    input  logic      vdd_high,
    output logic      long_sel
);
    always_comb begin
        unique case (mode)
            MODE_DIRECT:   long_sel = 1'b1;
            MODE_AUTO:     long_sel = ~vdd_high;
            MODE_PUMP_ON:  long_sel = 1'b1;
            MODE_PUMP_OFF: long_sel = 1'b0;
            default:       long_sel = 1'b1;
        endcase
    end
endmodule

// File: rtl/anasup_settle_timer.sv
module anasup_settle_timer #(
    parameter int SHORT_TICKS = 100,
    parameter int LONG_TICKS  = 550
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic long_in,
    output logic expire
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    logic          long_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // length is captured while idle and frozen for the whole count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    long_q <= 1'b0;
        else if (!run) long_q <= long_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    assign last   = long_q ? LONG_LAST : SHORT_LAST;
    assign expire = run && tick && (cnt_q == last);

    assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(long_q));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));
endmodule

// File: rtl/anasup_rail_decode.sv
module anasup_rail_decode
    import anasup_pkg::*;
(
    input  logic      rst_n,
    input  logic      on,
    input  logic      forced,
    input  sup_mode_e mode,
    input  logic      vdd_high,
    output logic      reg_en,
    output logic      pump_en,
    output logic      bypass_en
);
    always_comb begin
        reg_en    = 1'b0;
        pump_en   = 1'b0;
        bypass_en = 1'b0;
        unique case (mode)
            MODE_DIRECT: begin
                bypass_en = on;
            end
            MODE_AUTO: begin
                reg_en  = on;
                pump_en = on && (forced || !vdd_high);
            end
            MODE_PUMP_ON: begin
                reg_en  = on;
                pump_en = on;
            end
            MODE_PUMP_OFF: begin
                reg_en  = on;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (rst_n && mode == MODE_DIRECT)
            assert_direct_rails_off_R2: assert (!reg_en && !pump_en);
        if (rst_n && !on)
            assert_rails_need_ref_R4: assert (!reg_en && !pump_en && !bypass_en);
    end
endmodule

// File: rtl/anasup_ctrl.sv
module anasup_ctrl
    import anasup_pkg::*;
#(
    parameter int SHORT_TICKS = 100,
    parameter int LONG_TICKS  = 550
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       analog_req,
    input  logic       force_on,
    input  logic [1:0] supply_mode,
    input  logic       vdd_high,
    input  logic       tick_1us,
    output logic       ref_en,
    output logic       reg_en,
    output logic       pump_en,
    output logic       bypass_en,
    output logic       cmp_valid,
    output logic       ref_ready,
    output logic       osc_en
);
    seq_state_e state_q, state_d;
    sup_mode_e  mode;
    logic       want;
    logic       long_sel;
    logic       expire;
    logic       forced;

    assign mode = sup_mode_e'(supply_mode);
    assign want = analog_req | force_on;

    anasup_delay_sel u_sel (
        .mode     (mode),
        .vdd_high (vdd_high),
        .long_sel (long_sel)
    );

    anasup_settle_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SETTLE),
        .tick    (tick_1us),
        .long_in (long_sel),
        .expire  (expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!want)
            state_d = ST_OFF;
        else if (force_on)
            state_d = ST_FORCED;
        else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_SETTLE;
                ST_SETTLE: if (expire) state_d = ST_READY;
                ST_READY:  state_d = ST_READY;
                ST_FORCED: state_d = ST_READY;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        ref_en    = 1'b0;
        cmp_valid = 1'b0;
        forced    = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_SETTLE: ref_en = 1'b1;
            ST_READY: begin
                ref_en    = 1'b1;
                cmp_valid = 1'b1;
            end
            ST_FORCED: begin
                ref_en    = 1'b1;
                cmp_valid = 1'b1;
                forced    = 1'b1;
            end
            default: ;
        endcase
    end

    assign ref_ready = ref_en;
    assign osc_en    = ref_en;

    anasup_rail_decode u_rails (
        .rst_n     (rst_n),
        .on        (ref_en),
        .forced    (forced),
        .mode      (mode),
        .vdd_high  (vdd_high),
        .reg_en    (reg_en),
        .pump_en   (pump_en),
        .bypass_en (bypass_en)
    );

    assert_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !want |=> (!ref_en && !cmp_valid));

    assert_on_when_wanted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        want |=> ref_en);

    assert_force_opens_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> cmp_valid);

    assert_settle_waits_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !tick_1us) |=> (state_q != ST_READY));

    assert_release_keeps_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FORCED && analog_req) |=> cmp_valid);
endmodule

// File: tb/anasup_ctrl_tb.sv
module anasup_ctrl_tb;
    localparam int SHORT_N = 100;
    localparam int LONG_N  = 550;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic analog_req = 1'b0, force_on = 1'b0, vdd_high = 1'b0, tick_1us = 1'b0;
    logic [1:0] supply_mode = 2'b00;
    logic ref_en, reg_en, pump_en, bypass_en, cmp_valid, ref_ready, osc_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    anasup_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .analog_req(analog_req), .force_on(force_on),
        .supply_mode(supply_mode), .vdd_high(vdd_high), .tick_1us(tick_1us),
        .ref_en(ref_en), .reg_en(reg_en), .pump_en(pump_en), .bypass_en(bypass_en),
        .cmp_valid(cmp_valid), .ref_ready(ref_ready), .osc_en(osc_en)
    );

    // tick generator: one pulse every 3 clocks
    int tdiv = 0;
    always @(posedge clk) begin
        #4;
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick_1us = (tdiv == 0);
    end

    // behavioural reference model
    bit m_on = 0, m_valid = 0, m_forced = 0;
    int m_cnt = 0, m_len = 0;
    int meas = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on = 0; m_valid = 0; m_forced = 0; m_cnt = 0; meas = 0;
        end else begin
            if (!ref_en) meas = 0;
            else if (!cmp_valid && tick_1us) meas = meas + 1;
            if (!(analog_req || force_on)) begin
                m_on = 0; m_valid = 0; m_forced = 0;
            end else if (force_on) begin
                m_on = 1; m_valid = 1; m_forced = 1;
            end else if (!m_on) begin
                m_on = 1; m_valid = 0; m_forced = 0; m_cnt = 0;
                if (supply_mode == 2'b11 || (supply_mode == 2'b01 && vdd_high)) m_len = SHORT_N;
                else m_len = LONG_N;
            end else if (m_forced) begin
                m_forced = 0; m_valid = 1;
            end else if (!m_valid && tick_1us) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == m_len) m_valid = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_reg, e_pump, e_byp;
            e_reg  = m_on && supply_mode != 2'b00;
            e_byp  = m_on && supply_mode == 2'b00;
            e_pump = m_on && (supply_mode == 2'b10 ||
                              (supply_mode == 2'b01 && (m_forced || !vdd_high)));
            chk("R1 ref_en", ref_en, m_on);
            chk("R2/R4 bypass_en", bypass_en, e_byp);
            chk("R3/R4 reg_en", reg_en, e_reg);
            chk("R3/R6 pump_en", pump_en, e_pump);
            chk("R5/R8 cmp_valid", cmp_valid, m_valid);
            chk("R7 ref_ready", ref_ready, m_on);
            chk("R7 osc_en", osc_en, m_on);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic wait_valid(input string tag);
        int k = 0;
        while (!cmp_valid && k < 3000) begin cyc(1); k++; end
        chk({tag, " gate opened"}, cmp_valid, 1'b1);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R11 reset
        chk("R11 ref_en in reset", ref_en, 1'b0);
        chk("R11 cmp_valid in reset", cmp_valid, 1'b0);
        chk("R11 pump_en in reset", pump_en, 1'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R11 ref_en after reset", ref_en, 1'b0);

        // R5 short delay, mode 11
        supply_mode = 2'b11; analog_req = 1'b1;
        cyc(1);
        chk("R1 ref_en one edge after request", ref_en, 1'b1);
        wait_valid("R5 mode11");
        chk_int("R5 mode11 tick count", meas, SHORT_N);
        analog_req = 1'b0;
        cyc(1);
        chk("R8 gate closes with ref", cmp_valid, 1'b0);

        // R9 automatic mode, flag changes mid count
        supply_mode = 2'b01; vdd_high = 1'b1; analog_req = 1'b1;
        cyc(40);
        vdd_high = 1'b0;
        cyc(2);
        chk("R3 pump follows low supply", pump_en, 1'b1);
        wait_valid("R9 mode01");
        chk_int("R9 latched short length", meas, SHORT_N);
        analog_req = 1'b0;
        cyc(2);

        // R8 abort then re-enable, direct mode long delay
        supply_mode = 2'b00; analog_req = 1'b1;
        cyc(600);
        chk("R8 still settling", cmp_valid, 1'b0);
        analog_req = 1'b0;
        cyc(2);
        analog_req = 1'b1;
        cyc(1);
        chk("R2 bypass in direct mode", bypass_en, 1'b1);
        wait_valid("R8 restart");
        chk_int("R8 full count after restart", meas, LONG_N);
        analog_req = 1'b0;
        cyc(2);

        // R4 pump always on, long
        supply_mode = 2'b10; analog_req = 1'b1;
        wait_valid("R4 mode10");
        chk_int("R5 mode10 tick count", meas, LONG_N);
        analog_req = 1'b0;
        cyc(2);

        // R6/R10 force during settle in auto mode
        supply_mode = 2'b01; vdd_high = 1'b1; analog_req = 1'b1;
        cyc(30);
        force_on = 1'b1;
        cyc(1);
        chk("R6 force opens gate", cmp_valid, 1'b1);
        chk("R6 pump forced in auto", pump_en, 1'b1);
        force_on = 1'b0;
        cyc(1);
        chk("R10 gate held after release", cmp_valid, 1'b1);
        cyc(5);
        chk("R10 no restart", cmp_valid, 1'b1);
        analog_req = 1'b0;
        cyc(2);

        // R6 force alone from off
        supply_mode = 2'b11; force_on = 1'b1;
        cyc(1);
        chk("R6 gate with ref, no delay", cmp_valid, 1'b1);
        force_on = 1'b0;
        cyc(1);
        chk("R1 off when nothing wanted", ref_en, 1'b0);
        cyc(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule